// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns a single write to its control register into a complete raw NAND bus transaction. The control word picks which phases run. The phases are a first opcode, column address bytes, row address bytes, a second opcode followed by a settle gap, and data bytes in one direction. The phases that are picked always run in that fixed order. Host software loads the address, data, timing and geometry registers first. It then writes the control word with the start bit set and polls that bit until the block clears it.

On the flash side the block drives chip enable, command latch, address latch, write strobe, read strobe and an 8-bit data bus with a separate output enable. It also watches the ready/busy pin. A keep-selected bit leaves chip enable asserted after a sequence ends. This lets one flash operation, such as a page read setup and its following data reads, span several register-triggered sequences. The final sequence of the operation is issued with the bit clear, which releases chip enable. Strobe setup, width, hold and the post-opcode gap all come from programmable cycle counts.

Top module: `nand_seq`

## Requirements
- R1: After reset, chip enable is deasserted (`ce_no`=1), both strobes are high, CLE and ALE are low, `io_oe_o` is 0, and control bit 31 reads 0.
- R2: A control write (register address 0) with bit 31 set starts a sequence. Bit 31 reads 1 until every selected phase has finished, then reads 0, and the bus returns to idle.
- R3: The selected phases run in this order: first opcode (enable bit 16, value in bits 7:0), column (bit 17), row (bit 18), second opcode (bit 19, value in bits 15:8), data. CLE is high only on opcode bytes and ALE only on address bytes.
- R4: Address bytes go out least significant byte first. There are (geometry bits 5:4)+1 column bytes taken from register 1 and (geometry bits 7:6)+1 row bytes taken from register 2. The geometry register is at address 5.
- R5: Control bit 24 replaces the column and row phases with one address byte of value 0x00.
- R6: With control bit 30 set, `ce_no` stays 0 after the sequence ends. A sequence ending with bit 30 clear leaves `ce_no` at 1. While no sequence runs, `ce_no` does not change.
- R7: A sequence whose first opcode is enabled with value 0xFF runs with `ce_no` held at 1 throughout.
- R8: Bits 29:28 hold n, and the data phase moves n+1 bytes. Bit 21 selects a write and bit 20 a read. A write sends data register (address 3) bits 7:0 first. A read clears the data register and stores the k-th received byte in bits 8k+7:8k. During a read the bus is not driven.
- R9: The timing register (address 4) holds w0 in bits 5:0, w1 in 11:6, w2 in 17:12, w3 in 23:18 and w4 in 31:24. Each byte has w0 setup cycles, w1 strobe-low cycles, and then w2 (write) or w3 (read) hold cycles. A gap of w4 cycles follows the second opcode. A count of 0 acts as 1, and one idle cycle precedes each byte or gap.
- R10: Control bit 26 reads the ready/busy pin, delayed by one clock register.
- R11: A control write arriving while bit 31 reads 1 is ignored entirely.
- R12: A start with both bits 20 and 21 set produces no bus activity and leaves bit 31 at 0. It sets bit 27, and bit 27 stays set until the next accepted start that is free of this conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: 0 control, 1 column, 2 row, 3 data, 4 timing, 5 geometry |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| ce_no | output | 1 | Flash chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| io_o | output | 8 | Bus output data |
| io_oe_o | output | 1 | Bus output enable; 0 leaves the bus high impedance |
| io_i | input | 8 | Bus input data |
| rb_i | input | 1 | Flash ready (1) / busy (0) |

## Verification
The assertions assume the host issues a start only after polling bit 31 back to 0, and never writes the data register while a read sequence is filling it. The bench obeys both rules: every scenario waits for bit 31 to clear, and the only write made during a sequence is the deliberate ignored-control write. The bench's flash model changes `io_i` only on the negative clock edge after a read strobe rises. This keeps the input stable across the capture edge at the end of the strobe-low window, which the read assertions rely on.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int unsigned IO_W   = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned GEOM_W = 8;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned LANES  = DATA_W / IO_W;
  localparam int unsigned IDX_W  = $clog2(LANES);

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_COL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ROW  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd3;
  localparam logic [ADDR_W-1:0] A_TIME = 3'd4;
  localparam logic [ADDR_W-1:0] A_GEOM = 3'd5;

  localparam int unsigned B_START = 31;
  localparam logic [IO_W-1:0] OP_RESET = 8'hFF;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0, PH_OP1 = 3'd1, PH_COL = 3'd2, PH_ROW = 3'd3,
    PH_SPEC = 3'd4, PH_OP2 = 3'd5, PH_GAP = 3'd6, PH_DATA = 3'd7
  } phase_e;

  typedef enum logic [2:0] {
    XF_CMD, XF_ADDR, XF_WR, XF_RD, XF_GAP
  } xfer_e;

  typedef struct packed {
    logic            keep;
    logic [1:0]      size;
    logic            spec;
    logic            wr;
    logic            rd;
    logic            op2_en;
    logic            row_en;
    logic            col_en;
    logic            op1_en;
    logic [IO_W-1:0] op2;
    logic [IO_W-1:0] op1;
  } ctrl_t;
endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              err_i,
  input  logic              rdy_i,
  input  ctrl_t             ctrl_i,
  input  logic              rd_clr_i,
  input  logic              rd_vld_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IO_W-1:0]   rd_byte_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ld_o,
  output logic              start_o,
  output ctrl_t             ctrl_w_o,
  output logic [DATA_W-1:0] col_o,
  output logic [DATA_W-1:0] row_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] time_o,
  output logic [GEOM_W-1:0] geom_o
);
  logic [DATA_W-1:0] col_q, row_q, data_q, time_q;
  logic [GEOM_W-1:0] geom_q;

  assign ld_o    = we_i && (addr_i == A_CTRL) && !busy_i;
  assign start_o = ld_o && wdata_i[B_START];

  always_comb begin
    ctrl_w_o.keep   = wdata_i[30];
    ctrl_w_o.size   = wdata_i[29:28];
    ctrl_w_o.spec   = wdata_i[24];
    ctrl_w_o.wr     = wdata_i[21];
    ctrl_w_o.rd     = wdata_i[20];
    ctrl_w_o.op2_en = wdata_i[19];
    ctrl_w_o.row_en = wdata_i[18];
    ctrl_w_o.col_en = wdata_i[17];
    ctrl_w_o.op1_en = wdata_i[16];
    ctrl_w_o.op2    = wdata_i[15:8];
    ctrl_w_o.op1    = wdata_i[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      row_q  <= '0;
      data_q <= '0;
      time_q <= '0;
      geom_q <= '0;
    end else begin
      if (we_i && addr_i == A_COL)  col_q  <= wdata_i;
      if (we_i && addr_i == A_ROW)  row_q  <= wdata_i;
      if (we_i && addr_i == A_TIME) time_q <= wdata_i;
      if (we_i && addr_i == A_GEOM) geom_q <= wdata_i[GEOM_W-1:0];
      if (rd_clr_i)                 data_q <= '0;
      else if (rd_vld_i)            data_q[rd_idx_i*IO_W +: IO_W] <= rd_byte_i;
      else if (we_i && addr_i == A_DATA) data_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {busy_i, ctrl_i.keep, ctrl_i.size, err_i, rdy_i, 1'b0,
                          ctrl_i.spec, 2'b00, ctrl_i.wr, ctrl_i.rd, ctrl_i.op2_en,
                          ctrl_i.row_en, ctrl_i.col_en, ctrl_i.op1_en,
                          ctrl_i.op2, ctrl_i.op1};
      A_COL:   rdata_o = col_q;
      A_ROW:   rdata_o = row_q;
      A_DATA:  rdata_o = data_q;
      A_TIME:  rdata_o = time_q;
      A_GEOM:  rdata_o = {{(DATA_W-GEOM_W){1'b0}}, geom_q};
      default: rdata_o = '0;
    endcase
  end

  assign col_o  = col_q;
  assign row_o  = row_q;
  assign data_o = data_q;
  assign time_o = time_q;
  assign geom_o = geom_q;
endmodule

// File: rtl/nand_seq_cycle.sv
module nand_seq_cycle
  import nand_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  xfer_e            kind_i,
  input  logic [IO_W-1:0]  byte_i,
  input  logic [CNT_W-1:0] w_setup_i,
  input  logic [CNT_W-1:0] w_low_i,
  input  logic [CNT_W-1:0] w_hold_wr_i,
  input  logic [CNT_W-1:0] w_hold_rd_i,
  input  logic [CNT_W-1:0] w_gap_i,
  input  logic [IO_W-1:0]  io_i,
  output logic             done_o,
  output logic [IO_W-1:0]  rbyte_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic             we_no,
  output logic             re_no,
  output logic [IO_W-1:0]  io_o,
  output logic             io_oe_o
);
  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_LOW, E_HOLD} est_e;

  est_e             st_q;
  xfer_e            kind_q;
  logic [IO_W-1:0]  byte_q, rbyte_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act, is_rd;

  function automatic logic [CNT_W-1:0] ld(input logic [CNT_W-1:0] w);
    return (w == '0) ? '0 : w - 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= E_IDLE;
      kind_q  <= XF_GAP;
      byte_q  <= '0;
      rbyte_q <= '0;
      cnt_q   <= '0;
    end else if (start_i) begin
      kind_q <= kind_i;
      byte_q <= byte_i;
      if (kind_i == XF_GAP) begin
        st_q  <= E_HOLD;
        cnt_q <= ld(w_gap_i);
      end else begin
        st_q  <= E_SETUP;
        cnt_q <= ld(w_setup_i);
      end
    end else begin
      unique case (st_q)
        E_SETUP: if (cnt_q == '0) begin
                   st_q  <= E_LOW;
                   cnt_q <= ld(w_low_i);
                 end else cnt_q <= cnt_q - 1'b1;
        E_LOW:   if (cnt_q == '0) begin
                   st_q  <= E_HOLD;
                   cnt_q <= ld(is_rd ? w_hold_rd_i : w_hold_wr_i);
                   if (is_rd) rbyte_q <= io_i;
                 end else cnt_q <= cnt_q - 1'b1;
        E_HOLD:  if (cnt_q == '0) st_q <= E_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign is_rd   = (kind_q == XF_RD);
  assign act     = (st_q != E_IDLE) && (kind_q != XF_GAP);
  assign done_o  = (st_q == E_HOLD) && (cnt_q == '0);
  assign rbyte_o = rbyte_q;
  assign cle_o   = act && (kind_q == XF_CMD);
  assign ale_o   = act && (kind_q == XF_ADDR);
  assign io_oe_o = act && !is_rd;
  assign io_o    = io_oe_o ? byte_q : '0;
  assign we_no   = !(act && !is_rd && st_q == E_LOW);
  assign re_no   = !(act && is_rd && st_q == E_LOW);
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              start_i,
  input  ctrl_t             ctrl_w_i,
  input  logic [DATA_W-1:0] col_i,
  input  logic [DATA_W-1:0] row_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        geom_col_i,
  input  logic [1:0]        geom_row_i,
  input  logic              eng_done_i,
  output ctrl_t             ctrl_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              ce_act_o,
  output logic              eng_start_o,
  output xfer_e             eng_kind_o,
  output logic [IO_W-1:0]   eng_byte_o,
  output logic              rd_clr_o,
  output logic              rd_vld_o,
  output logic [IDX_W-1:0]  rd_idx_o
);
  ctrl_t            ctrl_q;
  phase_e           ph_q, first_ph, next_ph;
  logic [IDX_W-1:0] idx_q;
  logic             pend_q, err_q, ce_q, conflict, last;
  logic [IDX_W:0]   nbytes, nlast;

  function automatic logic [7:0] en_vec(input ctrl_t c);
    logic [7:0] e;
    e[0] = 1'b0;
    e[1] = c.op1_en;
    e[2] = c.col_en && !c.spec;
    e[3] = c.row_en && !c.spec;
    e[4] = c.spec;
    e[5] = c.op2_en;
    e[6] = c.op2_en;
    e[7] = c.rd || c.wr;
    return e;
  endfunction

  // lowest enabled phase strictly after p
  function automatic phase_e after(input phase_e p, input logic [7:0] en);
    phase_e r = PH_IDLE;
    for (int i = 7; i >= 1; i--)
      if (en[i] && (i > int'(p))) r = phase_e'(3'(i));
    return r;
  endfunction

  assign conflict = ctrl_w_i.rd && ctrl_w_i.wr;
  assign first_ph = after(PH_IDLE, en_vec(ctrl_w_i));
  assign next_ph  = after(ph_q, en_vec(ctrl_q));

  always_comb begin
    unique case (ph_q)
      PH_COL:  nbytes = {1'b0, geom_col_i} + 1'b1;
      PH_ROW:  nbytes = {1'b0, geom_row_i} + 1'b1;
      PH_DATA: nbytes = {1'b0, ctrl_q.size} + 1'b1;
      default: nbytes = 3'd1;
    endcase
  end
  assign nlast = nbytes - 1'b1;
  assign last  = (idx_q == nlast[IDX_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ph_q   <= PH_IDLE;
      idx_q  <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      ce_q   <= 1'b0;
    end else begin
      if (ld_i) ctrl_q <= ctrl_w_i;
      if (start_i) begin
        if (conflict) err_q <= 1'b1;
        else begin
          err_q <= 1'b0;
          if (first_ph != PH_IDLE) begin
            ph_q   <= first_ph;
            idx_q  <= '0;
            pend_q <= 1'b1;
            ce_q   <= !(ctrl_w_i.op1_en && ctrl_w_i.op1 == OP_RESET);
          end
        end
      end else if (pend_q) begin
        pend_q <= 1'b0;
      end else if (eng_done_i) begin
        if (!last) begin
          idx_q  <= idx_q + 1'b1;
          pend_q <= 1'b1;
        end else if (next_ph == PH_IDLE) begin
          ph_q <= PH_IDLE;
          ce_q <= ctrl_q.keep;
        end else begin
          ph_q   <= next_ph;
          idx_q  <= '0;
          pend_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    eng_byte_o = '0;
    unique case (ph_q)
      PH_OP1:  begin eng_kind_o = XF_CMD;  eng_byte_o = ctrl_q.op1; end
      PH_COL:  begin eng_kind_o = XF_ADDR; eng_byte_o = col_i[idx_q*IO_W +: IO_W]; end
      PH_ROW:  begin eng_kind_o = XF_ADDR; eng_byte_o = row_i[idx_q*IO_W +: IO_W]; end
      PH_SPEC: eng_kind_o = XF_ADDR;
      PH_OP2:  begin eng_kind_o = XF_CMD;  eng_byte_o = ctrl_q.op2; end
      PH_DATA: begin
                 eng_kind_o = ctrl_q.rd ? XF_RD : XF_WR;
                 eng_byte_o = data_i[idx_q*IO_W +: IO_W];
               end
      default: eng_kind_o = XF_GAP;
    endcase
  end

  assign eng_start_o = pend_q;
  assign ctrl_o      = ctrl_q;
  assign busy_o      = (ph_q != PH_IDLE);
  assign err_o       = err_q;
  assign ce_act_o    = ce_q;
  assign rd_clr_o    = start_i && !conflict && ctrl_w_i.rd;
  assign rd_vld_o    = eng_done_i && (ph_q == PH_DATA) && ctrl_q.rd;
  assign rd_idx_o    = idx_q;
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [IO_W-1:0]   io_o,
  output logic              io_oe_o,
  input  logic [IO_W-1:0]   io_i,
  input  logic              rb_i
);
  ctrl_t             ctrl_q, ctrl_w;
  logic              ld, start, busy, err, ce_act, rdy_q;
  logic              rd_clr, rd_vld, eng_start, eng_done;
  logic [IDX_W-1:0]  rd_idx;
  logic [IO_W-1:0]   eng_byte, rbyte;
  xfer_e             eng_kind;
  logic [DATA_W-1:0] col, row, data, tim;
  logic [GEOM_W-1:0] geom;
  logic [CNT_W-1:0]  w0, w1, w2, w3, w4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= rb_i;
  end

  assign w0 = CNT_W'(tim[5:0]);
  assign w1 = CNT_W'(tim[11:6]);
  assign w2 = CNT_W'(tim[17:12]);
  assign w3 = CNT_W'(tim[23:18]);
  assign w4 = CNT_W'(tim[31:24]);

  nand_seq_regs u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy),
    .err_i     (err),
    .rdy_i     (rdy_q),
    .ctrl_i    (ctrl_q),
    .rd_clr_i  (rd_clr),
    .rd_vld_i  (rd_vld),
    .rd_idx_i  (rd_idx),
    .rd_byte_i (rbyte),
    .rdata_o   (reg_rdata_o),
    .ld_o      (ld),
    .start_o   (start),
    .ctrl_w_o  (ctrl_w),
    .col_o     (col),
    .row_o     (row),
    .data_o    (data),
    .time_o    (tim),
    .geom_o    (geom)
  );

  nand_seq_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .ld_i        (ld),
    .start_i     (start),
    .ctrl_w_i    (ctrl_w),
    .col_i       (col),
    .row_i       (row),
    .data_i      (data),
    .geom_col_i  (geom[5:4]),
    .geom_row_i  (geom[7:6]),
    .eng_done_i  (eng_done),
    .ctrl_o      (ctrl_q),
    .busy_o      (busy),
    .err_o       (err),
    .ce_act_o    (ce_act),
    .eng_start_o (eng_start),
    .eng_kind_o  (eng_kind),
    .eng_byte_o  (eng_byte),
    .rd_clr_o    (rd_clr),
    .rd_vld_o    (rd_vld),
    .rd_idx_o    (rd_idx)
  );

  nand_seq_cycle u_cycle (
    .clk_i, .rst_ni,
    .start_i     (eng_start),
    .kind_i      (eng_kind),
    .byte_i      (eng_byte),
    .w_setup_i   (w0),
    .w_low_i     (w1),
    .w_hold_wr_i (w2),
    .w_hold_rd_i (w3),
    .w_gap_i     (w4),
    .io_i        (io_i),
    .done_o      (eng_done),
    .rbyte_o     (rbyte),
    .cle_o       (cle_o),
    .ale_o       (ale_o),
    .we_no       (we_no),
    .re_no       (re_no),
    .io_o        (io_o),
    .io_oe_o     (io_oe_o)
  );

  assign ce_no = !ce_act;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic ce_no,
  input logic cle_o,
  input logic ale_o,
  input logic we_no,
  input logic re_no,
  input logic io_oe_o
);
  // R3
  cle_ale_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));

  // R9
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));

  // R8
  oe_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !io_oe_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (we_no && re_no && !io_oe_o && !cle_o && !ale_o));

  // R6
  ce_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && $past(!busy_i)) |-> $stable(ce_no));

  // R4
  addr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> io_oe_o);
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy),
  .ce_no   (ce_no),
  .cle_o   (cle_o),
  .ale_o   (ale_o),
  .we_no   (we_no),
  .re_no   (re_no),
  .io_oe_o (io_oe_o)
);

// File: tb/tb_nand_seq.sv
`timescale 1ns/1ps
module tb_nand_seq;
  localparam logic [31:0] S_ = 32'h8000_0000, KEEP = 32'h4000_0000,
                          SPEC = 32'h0100_0000, WR = 32'h0020_0000,
                          RD = 32'h0010_0000, OP2 = 32'h0008_0000,
                          ROW = 32'h0004_0000, COL = 32'h0002_0000,
                          OP1 = 32'h0001_0000;
  localparam logic [31:0] T_ONES = (32'd1 << 24) | (32'd1 << 18) | (32'd1 << 12)
                                 | (32'd1 << 6) | 32'd1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        ce_n, cle, ale, we_n, re_n, oe, rb = 1'b1;
  logic [7:0]  io_out, io_in;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // bus monitor state
  logic [1:0] log_kind [64];
  logic [7:0] log_byte [64];
  logic       log_ce   [64];
  int         log_low  [64];
  int log_n = 0, rd_total = 0, rd_base = 0, ce_low_cnt = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  logic [7:0] rd_pat [4];

  always #10 clk = ~clk;

  nand_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ce_no(ce_n), .cle_o(cle),
    .ale_o(ale), .we_no(we_n), .re_no(re_n), .io_o(io_out), .io_oe_o(oe),
    .io_i(io_in), .rb_i(rb)
  );

  assign io_in = rd_pat[(rd_total - rd_base) & 3];

  always @(negedge clk) begin
    if (!we_n) begin
      if (prev_we) begin
        log_kind[log_n & 63] <= {ale, cle};
        log_byte[log_n & 63] <= io_out;
        log_ce[log_n & 63]   <= ce_n;
        log_low[log_n & 63]  <= 1;
        log_n <= log_n + 1;
      end else log_low[(log_n - 1) & 63] <= log_low[(log_n - 1) & 63] + 1;
    end
    if (re_n && !prev_re) rd_total <= rd_total + 1;
    if (!ce_n) ce_low_cnt <= ce_low_cnt + 1;
    prev_we <= we_n;
    prev_re <= re_n;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired: actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      reg_rd(3'd0, v);
      if (!v[31]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic chk_log(input string tag, input int i, input logic [1:0] k, input logic [7:0] b);
    chk({tag, " kind"}, 32'(log_kind[i & 63]), 32'(k));
    chk({tag, " byte"}, 32'(log_byte[i & 63]), 32'(b));
    chk({tag, " ce"}, 32'(log_ce[i & 63]), 32'(0));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    chk("R1 ce_no", 32'(ce_n), 1);
    chk("R1 strobes", {30'd0, we_n, re_n}, 3);
    chk("R1 cle/ale/oe", {29'd0, cle, ale, oe}, 0);
    reg_rd(3'd0, v);
    chk("R1 busy bit", 32'(v[31]), 0);
  endtask

  task automatic t_page_read();
    int base, n; logic [31:0] v;
    reg_wr(3'd4, T_ONES);
    reg_wr(3'd5, 32'h92);
    reg_wr(3'd1, 32'h0000_0834);
    reg_wr(3'd2, 32'h0001_2345);
    base = log_n;
    reg_wr(3'd0, S_ | KEEP | OP2 | ROW | COL | OP1 | (32'h30 << 8));
    reg_rd(3'd0, v);
    chk("R2 busy after start", 32'(v[31]), 1);
    wait_idle(n);
    @(negedge clk);
    chk("R3 count", 32'(log_n - base), 7);
    chk_log("R3 op1", base, 2'b01, 8'h00);
    chk_log("R4 col0", base + 1, 2'b10, 8'h34);
    chk_log("R4 col1", base + 2, 2'b10, 8'h08);
    chk_log("R4 row0", base + 3, 2'b10, 8'h45);
    chk_log("R4 row1", base + 4, 2'b10, 8'h23);
    chk_log("R4 row2", base + 5, 2'b10, 8'h01);
    chk_log("R3 op2", base + 6, 2'b01, 8'h30);
    chk("R6 ce kept", 32'(ce_n), 0);
    chk("R2 bus idle", {29'd0, we_n, re_n, oe}, 3'b110);
    // data read, releases chip enable
    rd_pat[0] = 8'hA1; rd_pat[1] = 8'hB2; rd_pat[2] = 8'hC3; rd_pat[3] = 8'hD4;
    rd_base = rd_total; base = log_n;
    reg_wr(3'd0, S_ | RD | (32'd3 << 28));
    wait_idle(n);
    @(negedge clk);
    reg_rd(3'd3, v);
    chk("R8 read word", v, 32'hD4C3_B2A1);
    chk("R8 read strobes", 32'(rd_total - rd_base), 4);
    chk("R8 no write strobe", 32'(log_n - base), 0);
    chk("R6 ce released", 32'(ce_n), 1);
  endtask

  task automatic t_erase();
    int base, n;
    base = log_n;
    reg_wr(3'd0, S_ | ROW | OP2 | OP1 | (32'hD0 << 8) | 32'h60);
    wait_idle(n);
    @(negedge clk);
    chk("R3 erase count", 32'(log_n - base), 5);
    chk_log("R3 erase op1", base, 2'b01, 8'h60);
    chk_log("R4 erase row0", base + 1, 2'b10, 8'h45);
    chk_log("R4 erase row2", base + 3, 2'b10, 8'h01);
    chk_log("R3 erase op2", base + 4, 2'b01, 8'hD0);
    chk("R6 erase ce", 32'(ce_n), 1);
  endtask

  task automatic t_write();
    int base, n;
    reg_wr(3'd3, 32'h4433_2211);
    base = log_n;
    reg_wr(3'd0, S_ | WR | (32'd3 << 28));
    wait_idle(n);
    @(negedge clk);
    chk("R8 write count", 32'(log_n - base), 4);
    for (int i = 0; i < 4; i++)
      chk_log("R8 write byte", base + i, 2'b00, 8'(8'h11 * (i + 1)));
  endtask

  task automatic t_read_id();
    int base, n; logic [31:0] v;
    base = log_n;
    reg_wr(3'd0, S_ | KEEP | SPEC | COL | ROW | OP1 | 32'h90);
    wait_idle(n);
    @(negedge clk);
    chk("R5 count", 32'(log_n - base), 2);
    chk_log("R5 op", base, 2'b01, 8'h90);
    chk_log("R5 addr", base + 1, 2'b10, 8'h00);
    reg_wr(3'd3, 32'hFFFF_FFFF);
    rd_pat[0] = 8'h2C; rd_base = rd_total;
    reg_wr(3'd0, S_ | RD);
    wait_idle(n);
    @(negedge clk);
    reg_rd(3'd3, v);
    chk("R8 single byte", v, 32'h0000_002C);
    chk("R6 id ce released", 32'(ce_n), 1);
  endtask

  task automatic t_reset_op();
    int base, n, ce0;
    base = log_n; ce0 = ce_low_cnt;
    reg_wr(3'd0, S_ | OP1 | 32'hFF);
    wait_idle(n);
    @(negedge clk);
    chk("R7 count", 32'(log_n - base), 1);
    chk("R7 byte", 32'(log_byte[base & 63]), 32'hFF);
    chk("R7 ce at strobe", 32'(log_ce[base & 63]), 1);
    chk("R7 ce never low", 32'(ce_low_cnt - ce0), 0);
  endtask

  task automatic t_timing();
    int n, base;
    reg_wr(3'd4, (32'd5 << 24) | (32'd1 << 18) | (32'd4 << 12) | (32'd3 << 6) | 32'd2);
    base = log_n;
    reg_wr(3'd0, S_ | OP1 | 32'h70);
    wait_idle(n);
    chk("R9 single cmd cycles", 32'(n), 10);
    chk("R9 strobe low width", 32'(log_low[base & 63]), 3);
    reg_wr(3'd0, S_ | OP1 | OP2 | 32'h70);
    wait_idle(n);
    chk("R9 two cmds plus gap", 32'(n), 26);
    reg_wr(3'd4, 32'd0);
    base = log_n;
    reg_wr(3'd0, S_ | OP1 | 32'h70);
    wait_idle(n);
    chk("R9 zero counts", 32'(n), 4);
    chk("R9 zero low width", 32'(log_low[base & 63]), 1);
    reg_wr(3'd4, (32'd1 << 24) | (32'd6 << 18) | (32'd1 << 12) | (32'd2 << 6) | 32'd1);
    rd_base = rd_total;
    reg_wr(3'd0, S_ | RD);
    wait_idle(n);
    chk("R9 read hold", 32'(n), 10);
    reg_wr(3'd4, T_ONES);
  endtask

  task automatic t_ready();
    logic [31:0] v;
    @(negedge clk); rb = 1'b0;
    @(negedge clk); @(negedge clk);
    reg_rd(3'd0, v);
    chk("R10 busy pin", 32'(v[26]), 0);
    rb = 1'b1;
    @(negedge clk); @(negedge clk);
    reg_rd(3'd0, v);
    chk("R10 ready pin", 32'(v[26]), 1);
  endtask

  task automatic t_ignore();
    int base, n; logic [31:0] v;
    reg_wr(3'd4, (32'd20 << 6) | 32'd1 | (32'd1 << 12));
    base = log_n;
    reg_wr(3'd0, S_ | OP1 | 32'hA5);
    @(negedge clk); @(negedge clk);
    reg_wr(3'd0, S_ | OP1 | OP2 | 32'h55);
    wait_idle(n);
    @(negedge clk);
    chk("R11 strobes", 32'(log_n - base), 1);
    chk("R11 byte sent", 32'(log_byte[base & 63]), 32'hA5);
    reg_rd(3'd0, v);
    chk("R11 control kept", v[19:0], 20'h1_00A5);
    reg_wr(3'd4, T_ONES);
  endtask

  task automatic t_error();
    int base, n; logic [31:0] v;
    base = log_n; rd_base = rd_total;
    reg_wr(3'd0, S_ | RD | WR | OP1 | 32'h11);
    reg_rd(3'd0, v);
    chk("R12 error set", 32'(v[27]), 1);
    chk("R12 not busy", 32'(v[31]), 0);
    repeat (4) @(negedge clk);
    chk("R12 no bus strobes", 32'(log_n - base + rd_total - rd_base), 0);
    reg_wr(3'd0, S_ | OP1 | 32'h70);
    wait_idle(n);
    reg_rd(3'd0, v);
    chk("R12 error cleared", 32'(v[27]), 0);
  endtask

  initial begin
    rd_pat[0] = '0; rd_pat[1] = '0; rd_pat[2] = '0; rd_pat[3] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_page_read();
    t_erase();
    t_write();
    t_read_id();
    t_reset_op();
    t_timing();
    t_ready();
    t_ignore();
    t_error();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule